// File: doc/BRIEF.md
# Always-On GPIO Controller with Polarity-Normalised Interrupt Lines

This block is a small general-purpose I/O controller for an always-on power domain. Software reaches it through a simple 32-bit register bus. It controls a set of pads through output-enable and output-data registers, and it reports the pad levels through an input register. The pad levels pass through a two-flop synchronizer before anything inside the block uses them.

A contiguous window of pins can also serve as interrupt sources. Software moves a pin in that window into the interrupt function through a function-select register, which holds two bits per pin. A per-line polarity register then chooses whether the pin signals when it is high or when it is low. Every line presented to the parent interrupt controller is active-high and level-type. The parent does any edge capture, masking and acknowledge.

Interrupt line n is tied to pin n + `IRQ_BASE`. With the default parameters, lines 0 to 5 come from pins 8 to 13.

Top module: `aon_gpio_irq`

## Requirements
- R1: While reset is active and right after reset, every stored register is 0. All `pad_oe` bits are 0 and all `irq_out` bits are 0.
- R2: The bus has two access types. A write takes effect at the rising edge where `bus_sel`=1 and `bus_wr`=1. A read returns data on `bus_rdata` in the same cycle when `bus_sel`=1 and `bus_wr`=0; otherwise `bus_rdata` is 0. The registers, by byte address, are:
  - polarity at 0x290, holding `NUM_IRQ` bits;
  - function select at 0x294, holding all 32 bits;
  - output enable at 0x29C, holding `NUM_PINS` bits;
  - output data at 0x2A0, holding `NUM_PINS` bits;
  - input at 0x2A4, read-only.
  Bits above a register's stored width read as 0. `pad_oe` equals the output-enable register.
- R3: Each `pad_out` bit equals the output-data bit ANDed with the output-enable bit of the same pin. A pin that is not enabled drives 0.
- R4: The input register returns `pad_in` after a two-flop synchronizer. A pad change made before a rising edge becomes readable after the second rising edge. Writes to the input register have no effect.
- R5: Line n follows pin p = n + `IRQ_BASE`. The line is enabled by bit (2·p) mod 32 of the function-select register. When the line is enabled and polarity bit n is 1, `irq_out[n]` is 1 exactly while the pin is high.
- R6: When the enable bit of a line is 0, `irq_out[n]` stays 0 whatever the pin level and the polarity. The other bit of the pin's 2-bit function field has no effect on the line.
- R7: When the line is enabled and polarity bit n is 0, `irq_out[n]` is 1 exactly while the pin is low.
- R8: A read of any address that is not one of the five register addresses returns 0. This includes addresses with bits [1:0] not equal to 0. A write to such an address changes no register.
- R9: A pad change reaches `irq_out` at the third rising edge after it is made. A change to the function-select or polarity register reaches `irq_out` at the rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; released inside the block on the clock |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| pad_in | input | NUM_PINS | Pad levels, asynchronous to `clk` |
| pad_out | output | NUM_PINS | Pad drive values |
| pad_oe | output | NUM_PINS | Pad drive enables |
| irq_out | output | NUM_IRQ | Active-high level interrupt lines to the parent controller |

## Verification
The bench builds the block with its default parameters: 22 pins and a 6-line interrupt window that starts at pin 8. The enable bits therefore sit at the even positions 16 to 26 of the function-select register. With these values, software can write the odd bit next to each enable and the enable bits of pins outside the window, so both can be shown to leave the lines untouched. Because the output-enable, output-data and polarity registers are narrower than the bus, the masking of the upper bits can also be seen at the read port. Random register writes are mixed with random pad patterns, and each cycle-exact latency is checked with directed sequences.

// File: rtl/aon_gpio_pkg.sv
package aon_gpio_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 12;

  // Byte addresses of the register words
  localparam logic [ADDR_W-1:0] ADR_POLARITY = 12'h290;
  localparam logic [ADDR_W-1:0] ADR_FUNCSEL  = 12'h294;
  localparam logic [ADDR_W-1:0] ADR_DRV_EN   = 12'h29C;
  localparam logic [ADDR_W-1:0] ADR_DRV_VAL  = 12'h2A0;
  localparam logic [ADDR_W-1:0] ADR_PIN_LVL  = 12'h2A4;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_POLARITY,
    RSEL_FUNCSEL,
    RSEL_DRV_EN,
    RSEL_DRV_VAL,
    RSEL_PIN_LVL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = RSEL_NONE;
    if (a == ADR_POLARITY) s = RSEL_POLARITY;
    if (a == ADR_FUNCSEL)  s = RSEL_FUNCSEL;
    if (a == ADR_DRV_EN)   s = RSEL_DRV_EN;
    if (a == ADR_DRV_VAL)  s = RSEL_DRV_VAL;
    if (a == ADR_PIN_LVL)  s = RSEL_PIN_LVL;
    return s;
  endfunction

endpackage

// File: rtl/aon_gpio_rst_sync.sv
module aon_gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/aon_gpio_in_sync.sv
module aon_gpio_in_sync #(
  parameter int unsigned WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/aon_gpio_regs.sv
module aon_gpio_regs
  import aon_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned NUM_IRQ  = 6,
  parameter int unsigned IRQ_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  output logic [NUM_PINS-1:0] drv_en_o,
  output logic [NUM_PINS-1:0] drv_val_o,
  output logic [NUM_IRQ-1:0]  polarity_o,
  output logic [NUM_IRQ-1:0]  line_en_o
);

  reg_sel_e sel;

  logic [NUM_IRQ-1:0]  polarity_q, polarity_d;
  logic [BUS_W-1:0]    funcsel_q,  funcsel_d;
  logic [NUM_PINS-1:0] drv_en_q,   drv_en_d;
  logic [NUM_PINS-1:0] drv_val_q,  drv_val_d;

  logic we_polarity, we_funcsel, we_drv_en, we_drv_val;

  assign sel = decode_addr(bus_addr);

  // Clock enables, one per stored register
  always_comb begin
    we_polarity = bus_sel && bus_wr && (sel == RSEL_POLARITY);
    we_funcsel  = bus_sel && bus_wr && (sel == RSEL_FUNCSEL);
    we_drv_en   = bus_sel && bus_wr && (sel == RSEL_DRV_EN);
    we_drv_val  = bus_sel && bus_wr && (sel == RSEL_DRV_VAL);
  end

  // Next-state values
  always_comb begin
    polarity_d = we_polarity ? bus_wdata[NUM_IRQ-1:0]  : polarity_q;
    funcsel_d  = we_funcsel  ? bus_wdata               : funcsel_q;
    drv_en_d   = we_drv_en   ? bus_wdata[NUM_PINS-1:0] : drv_en_q;
    drv_val_d  = we_drv_val  ? bus_wdata[NUM_PINS-1:0] : drv_val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polarity_q <= '0;
      funcsel_q  <= '0;
      drv_en_q   <= '0;
      drv_val_q  <= '0;
    end else begin
      polarity_q <= polarity_d;
      funcsel_q  <= funcsel_d;
      drv_en_q   <= drv_en_d;
      drv_val_q  <= drv_val_d;
    end
  end

  // Read path, same-cycle
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (sel)
        RSEL_POLARITY: bus_rdata[NUM_IRQ-1:0]  = polarity_q;
        RSEL_FUNCSEL:  bus_rdata               = funcsel_q;
        RSEL_DRV_EN:   bus_rdata[NUM_PINS-1:0] = drv_en_q;
        RSEL_DRV_VAL:  bus_rdata[NUM_PINS-1:0] = drv_val_q;
        RSEL_PIN_LVL:  bus_rdata[NUM_PINS-1:0] = pin_lvl_i;
        default:       bus_rdata               = '0;
      endcase
    end
  end

  // Pick out the interrupt-enable bit of each window pin
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line_en
    localparam int unsigned PIN = IRQ_BASE + n;
    localparam int unsigned FB  = (2 * PIN) % BUS_W;
    assign line_en_o[n] = funcsel_q[FB];
  end

  assign drv_en_o   = drv_en_q;
  assign drv_val_o  = drv_val_q;
  assign polarity_o = polarity_q;

endmodule

// File: rtl/aon_gpio_irq_map.sv
module aon_gpio_irq_map #(
  parameter int unsigned NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] win_lvl_i,
  input  logic [NUM_IRQ-1:0] line_en_i,
  input  logic [NUM_IRQ-1:0] polarity_i,
  output logic [NUM_IRQ-1:0] irq_o
);

  logic [NUM_IRQ-1:0] irq_d;
  logic [NUM_IRQ-1:0] irq_q;

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    // Match of pin level with programmed sense gives an active-high request
    always_comb begin
      irq_d[n] = line_en_i[n] & ~(win_lvl_i[n] ^ polarity_i[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/aon_gpio_irq.sv
module aon_gpio_irq
  import aon_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned NUM_IRQ  = 6,
  parameter int unsigned IRQ_BASE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_IRQ-1:0]  irq_out
);

  localparam int unsigned WIN_LO = IRQ_BASE;
  localparam int unsigned WIN_HI = IRQ_BASE + NUM_IRQ - 1;

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] drv_en;
  logic [NUM_PINS-1:0] drv_val;
  logic [NUM_IRQ-1:0]  polarity;
  logic [NUM_IRQ-1:0]  line_en;

  aon_gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  aon_gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pad_in),
    .sync_o  (pin_sync)
  );

  aon_gpio_regs #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .IRQ_BASE (IRQ_BASE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_lvl_i  (pin_sync),
    .drv_en_o   (drv_en),
    .drv_val_o  (drv_val),
    .polarity_o (polarity),
    .line_en_o  (line_en)
  );

  aon_gpio_irq_map #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .win_lvl_i  (pin_sync[WIN_HI:WIN_LO]),
    .line_en_i  (line_en),
    .polarity_i (polarity),
    .irq_o      (irq_out)
  );

  assign pad_oe  = drv_en;
  assign pad_out = drv_val & drv_en;

endmodule

// File: rtl/aon_gpio_irq_chk.sv
module aon_gpio_irq_chk #(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned NUM_IRQ  = 6,
  parameter int unsigned IRQ_BASE = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [11:0]         bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pin_sync,
  input logic [NUM_IRQ-1:0]  line_en,
  input logic [NUM_IRQ-1:0]  polarity,
  input logic [NUM_IRQ-1:0]  irq_out
);

  logic [1:0] age_q;
  logic       unmapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assign unmapped = (bus_addr != 12'h290) && (bus_addr != 12'h294) &&
                    (bus_addr != 12'h29C) && (bus_addr != 12'h2A0) &&
                    (bus_addr != 12'h2A4);

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);  // R3

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (pin_sync == $past(pad_in, 2)));  // R4

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && unmapped) |-> (bus_rdata == 32'd0));  // R8

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    localparam int unsigned PIN = IRQ_BASE + n;

    AST_LINE_OFF_WHEN_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en[n] |=> !irq_out[n]);  // R6

    AST_LINE_ON_WHEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en[n] && (pin_sync[PIN] == polarity[n])) |=> irq_out[n]);  // R5

    AST_LINE_OFF_WHEN_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sync[PIN] != polarity[n]) |=> !irq_out[n]);  // R7
  end

endmodule

bind aon_gpio_irq aon_gpio_irq_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_IRQ  (NUM_IRQ),
  .IRQ_BASE (IRQ_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pin_sync  (pin_sync),
  .line_en   (line_en),
  .polarity  (polarity),
  .irq_out   (irq_out)
);

// File: tb/aon_gpio_irq_test.sv
module aon_gpio_irq_test;

  localparam int unsigned NP   = 22;
  localparam int unsigned NI   = 6;
  localparam int unsigned BASE = 8;
  localparam logic [31:0] PIN_MASK = (32'd1 << NP) - 32'd1;
  localparam logic [31:0] IRQ_MASK = (32'd1 << NI) - 32'd1;

  localparam logic [11:0] A_POL = 12'h290;
  localparam logic [11:0] A_FS  = 12'h294;
  localparam logic [11:0] A_OE  = 12'h29C;
  localparam logic [11:0] A_DO  = 12'h2A0;
  localparam logic [11:0] A_DI  = 12'h2A4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic [NI-1:0] irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Shadow state built from the requirements
  logic [31:0] m_pol, m_fs, m_oe, m_do;

  always #2 clk = ~clk;

  aon_gpio_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (a)
      A_POL: m_pol = d & IRQ_MASK;
      A_FS:  m_fs  = d;
      A_OE:  m_oe  = d & PIN_MASK;
      A_DO:  m_do  = d & PIN_MASK;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] exp_reg(input logic [11:0] a);
    case (a)
      A_POL:   return m_pol;
      A_FS:    return m_fs;
      A_OE:    return m_oe;
      A_DO:    return m_do;
      A_DI:    return {{(32-NP){1'b0}}, pad_in};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_irq();
    logic [31:0] e;
    e = '0;
    for (int n = 0; n < NI; n++) begin
      int unsigned p;
      p = BASE + n;
      e[n] = m_fs[(2 * p) % 32] && (pad_in[p] == m_pol[n]);
    end
    return e;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    check({tag, " R5 R6 R7 irq_out"}, {{(32-NI){1'b0}}, irq_out}, exp_irq());
    check({tag, " R2 pad_oe"}, {{(32-NP){1'b0}}, pad_oe}, m_oe);
    check({tag, " R3 pad_out"}, {{(32-NP){1'b0}}, pad_out}, m_do & m_oe);
    bus_read(A_POL, d); check({tag, " R2 polarity read"}, d, exp_reg(A_POL));
    bus_read(A_FS,  d); check({tag, " R2 funcsel read"},  d, exp_reg(A_FS));
    bus_read(A_OE,  d); check({tag, " R2 drive-enable read"}, d, exp_reg(A_OE));
    bus_read(A_DO,  d); check({tag, " R2 drive-value read"},  d, exp_reg(A_DO));
    bus_read(A_DI,  d); check({tag, " R4 input read"},    d, exp_reg(A_DI));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] addrs [7];
    void'($urandom(32'd20240611));
    addrs[0] = A_POL; addrs[1] = A_FS; addrs[2] = A_OE; addrs[3] = A_DO;
    addrs[4] = A_DI;  addrs[5] = 12'h298; addrs[6] = 12'h291;
    m_pol = '0; m_fs = '0; m_oe = '0; m_do = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = NP'(32'h0000_3F00);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low while reset is held, even with window pins high
    check("R1 irq_out in reset", {26'd0, irq_out}, 32'd0);
    check("R1 pad_oe in reset", {10'd0, pad_oe}, 32'd0);
    rst_n = 1'b1;
    settle();
    check_all("R1 after reset");

    // R2/R3: widths, masking and pad drive
    bus_write(A_OE, 32'hFFFF_FFFF);
    bus_write(A_DO, 32'hFFFF_FFFF);
    bus_write(A_POL, 32'hFFFF_FFFF);
    bus_write(A_FS, 32'hA5A5_A5A5);
    settle();
    check_all("R2 masking");
    bus_write(A_OE, 32'h000F_0F0F);
    bus_write(A_DO, 32'h0033_3333);
    settle();
    check("R3 gated drive", {10'd0, pad_out}, 32'h0003_0303);

    // R4: two-edge visibility and write-ignore
    pad_in = '0;
    settle();
    pad_in = NP'(32'h0012_3456);
    @(negedge clk);
    bus_read(A_DI, d); check("R4 not yet visible after one edge", d, 32'd0);
    bus_read(A_DI, d); check("R4 visible after second edge", d, 32'h0012_3456);
    bus_write(A_DI, 32'hFFFF_FFFF);
    bus_read(A_DI, d); check("R4 write to input ignored", d, 32'h0012_3456);

    // R5: enable lines 0..5 (pins 8..13 -> bits 16..26), high sense
    bus_write(A_FS, 32'h0555_0000);
    bus_write(A_POL, 32'h0000_003F);
    pad_in = NP'(32'h0000_3F00);
    settle();
    check("R5 high sense, pins high", {26'd0, irq_out}, 32'h3F);
    pad_in = '0;
    settle();
    check("R5 high sense, pins low", {26'd0, irq_out}, 32'h00);

    // R7: low sense
    bus_write(A_POL, 32'h0);
    settle();
    check("R7 low sense, pins low", {26'd0, irq_out}, 32'h3F);
    pad_in = NP'(32'h0000_0A00);
    settle();
    check("R7 low sense, pins 9 and 11 high", {26'd0, irq_out}, 32'h35);

    // R6: disable line 2 (bit 20); odd-bit-only enable for line 0
    pad_in = '0;
    bus_write(A_FS, 32'h0545_0000);
    settle();
    check("R6 line 2 disabled", {26'd0, irq_out}, 32'h3B);
    bus_write(A_FS, 32'hFAAA_FFFF);
    settle();
    check("R6 odd bits and outside pins only", {26'd0, irq_out}, 32'h00);

    // R9: cycle timing of pad path and config path
    bus_write(A_FS, 32'h0000_0001 << 16);
    bus_write(A_POL, 32'h1);
    pad_in = '0;
    settle();
    pad_in = NP'(32'h0000_0100);
    @(negedge clk); @(negedge clk);
    check("R9 pad path old after two edges", {26'd0, irq_out}, 32'h0);
    @(negedge clk);
    check("R9 pad path new after third edge", {26'd0, irq_out}, 32'h1);
    bus_write(A_POL, 32'h0);
    check("R9 config path unchanged at write edge", {26'd0, irq_out}, 32'h1);
    @(negedge clk);
    check("R9 config path one edge after write", {26'd0, irq_out}, 32'h0);

    // R8: unmapped and misaligned addresses
    bus_write(12'h298, 32'hFFFF_FFFF);
    bus_write(12'h296, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h2A8, 32'hFFFF_FFFF);
    settle();
    check_all("R8 writes to unmapped");
    bus_read(12'h298, d); check("R8 read 0x298", d, 32'd0);
    bus_read(12'h2A2, d); check("R8 read misaligned 0x2A2", d, 32'd0);
    bus_read(12'hFFC, d); check("R8 read 0xFFC", d, 32'd0);

    // Random mix
    for (int it = 0; it < 120; it++) begin
      int unsigned k;
      k = $urandom_range(6, 0);
      bus_write(addrs[k], $urandom());
      if ($urandom_range(1, 0) == 1) pad_in = NP'($urandom());
      settle();
      check_all("random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule